// File: doc/BRIEF.md
# RGB Bar-Graph Scan Controller

This block refreshes a 48-segment RGB bar graph that is wired as a common-anode matrix of 16 groups. Each group holds three segments, and each segment has a red, a green and a blue LED. The block drives the matrix through a panel-style serial interface. A 4-bit group address goes to an external 4-to-16 decoder that enables one anode. A blank line switches every anode off. A shift clock and one serial data line, shared by all three colours, carry the 16-bit low-side word for a group, and a latch strobe moves that word to the cathode sinks.

Each segment holds a 24-bit colour in an internal memory, and a simple write port fills that memory. Brightness comes from binary-coded modulation. A frame is eight bit planes. Within a plane, all 16 groups are shown in turn, and each group is unblanked for a base period scaled by the weight of that plane. For every group the block does the following, in order:

1. Blank the display.
2. Shift the word.
3. Latch the word.
4. Set the address.
5. Wait one settling clock.
6. Unblank.

The settling clock keeps light from leaking onto a neighbouring group.

Top module: `rgb_bar_scan`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` as the colour of segment `wr_idx` (0 to 47). Red is in bits 23:16, green in bits 15:8 and blue in bits 7:0. Segment number = 3 * group + position in group.
- R2: A write whose `wr_idx` is 48 to 63 changes no stored colour and does not alias onto a lower index.
- R3: For group g in bit plane k, exactly 16 bits are shifted between latches, most significant bit first. Word bit 3s+0 is bit k of the red channel of segment 3g+s, bit 3s+1 is bit k of green, and bit 3s+2 is bit k of blue. Bits 15 to 9 are 0.
- R4: `sclk` runs at the system clock divided by 4: two clocks high and two clocks low. `sdata` changes only while `sclk` is low, at the falling edge, and `sclk` toggles only while `blank` is high.
- R5: `latch` is a single-clock pulse after the 16th shift-clock rise, and it occurs only while `blank` is high.
- R6: `row_addr` changes only while `blank` is high. `blank` falls only after `latch` has been low for at least one clock and `row_addr` has been stable for at least one clock.
- R7: In bit plane k, `blank` stays low for exactly BASE_TICKS * 2^k clocks per group.
- R8: Groups are shown in order 0 to 15 within a plane, and planes in order 0 to 7. The sequence then repeats, so a frame is 128 group displays.
- R9: Reset state:
  - `blank` is high.
  - `latch`, `sclk` and `sdata` are low.
  - `row_addr` is 0.
  - All stored colours are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Colour write strobe |
| wr_idx | input | 6 | Segment index of the write |
| wr_data | input | 24 | Colour {R, G, B}, 8 bits each |
| row_addr | output | 4 | Group address to the external decoder |
| blank | output | 1 | High turns all anodes off |
| sclk | output | 1 | Shift clock |
| latch | output | 1 | Latch strobe for the shifted word |
| sdata | output | 1 | Serial cathode data, MSB first |

## Verification
The bench builds the block with BASE_TICKS = 1 and leaves the geometry at its defaults. Each bit plane is then shown for 1, 2, 4 and up to 128 clocks, so a full frame of all 16 groups and all eight planes takes about 13,000 clocks. Several complete frames therefore fit in one run, each checked word by word against a model of the colour memory. This covers both the shortest unblank window (one clock, plane 0) and the wrap from plane 7 back to plane 0.

// File: rtl/rgb_bar_scan.sv
module rgb_bar_scan #(
  parameter int GROUPS     = 16,
  parameter int SEGS       = 3,
  parameter int CHAN_BITS  = 8,
  parameter int WORD_W     = 16,
  parameter int BASE_TICKS = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [$clog2(GROUPS*SEGS)-1:0]        wr_idx,
  input  logic [3*CHAN_BITS-1:0]                wr_data,
  output logic [$clog2(GROUPS)-1:0]             row_addr,
  output logic                                  blank,
  output logic                                  sclk,
  output logic                                  latch,
  output logic                                  sdata
);
  localparam int NSEG  = GROUPS * SEGS;
  localparam int IDX_W = $clog2(NSEG);
  localparam int ROW_W = $clog2(GROUPS);
  localparam int PL_W  = $clog2(CHAN_BITS);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int PX_W  = 3 * CHAN_BITS;
  localparam int CNT_W = $clog2(BASE_TICKS + 1) + CHAN_BITS;

  typedef enum logic [2:0] {S_LOAD, S_SHIFT, S_LATCH, S_SETTLE, S_UNBLANK, S_SHOW} state_t;

  state_t             state;
  logic [PX_W-1:0]    mem [NSEG];
  logic [ROW_W-1:0]   grp;
  logic [PL_W-1:0]    plane;
  logic [WORD_W-1:0]  word, sh;
  logic [BIT_W-1:0]   bit_cnt;
  logic [1:0]         phase;
  logic [CNT_W-1:0]   cnt;

  wire wr_ok   = wr_en && ({1'b0, wr_idx} < (IDX_W+1)'(NSEG));
  wire last_g  = (grp == ROW_W'(GROUPS - 1));
  wire last_pl = (plane == PL_W'(CHAN_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) mem[i] <= '0;
    end else if (wr_ok) begin
      mem[wr_idx] <= wr_data;
    end
  end

  for (genvar gs = 0; gs < SEGS; gs++) begin : g_seg
    for (genvar gc = 0; gc < 3; gc++) begin : g_chan
      logic [CHAN_BITS-1:0] chv;
      assign chv = mem[IDX_W'(grp * SEGS + gs)][(2-gc)*CHAN_BITS +: CHAN_BITS];
      assign word[gs*3 + gc] = chv[plane];
    end
  end
  if (WORD_W > 3*SEGS) begin : g_pad
    assign word[WORD_W-1:3*SEGS] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_LOAD;
      grp      <= '0;
      plane    <= '0;
      sh       <= '0;
      bit_cnt  <= '0;
      phase    <= '0;
      cnt      <= '0;
      row_addr <= '0;
      blank    <= 1'b1;
      sclk     <= 1'b0;
      latch    <= 1'b0;
      sdata    <= 1'b0;
    end else begin
      case (state)
        S_LOAD: begin
          sh      <= word;
          sdata   <= word[WORD_W-1];
          bit_cnt <= BIT_W'(WORD_W - 1);
          phase   <= '0;
          state   <= S_SHIFT;
        end
        S_SHIFT: begin
          phase <= phase + 2'd1;
          if (phase == 2'd1) sclk <= 1'b1;
          if (phase == 2'd3) begin
            sclk <= 1'b0;
            if (bit_cnt == '0) begin
              sdata <= 1'b0;
              state <= S_LATCH;
            end else begin
              sdata   <= sh[bit_cnt - 1'b1];
              bit_cnt <= bit_cnt - 1'b1;
            end
          end
        end
        S_LATCH: begin
          latch    <= 1'b1;
          row_addr <= grp;
          state    <= S_SETTLE;
        end
        S_SETTLE: begin
          latch <= 1'b0;
          state <= S_UNBLANK;
        end
        S_UNBLANK: begin
          blank <= 1'b0;
          cnt   <= (CNT_W'(BASE_TICKS) << plane) - CNT_W'(1);
          state <= S_SHOW;
        end
        S_SHOW: begin
          if (cnt == '0) begin
            blank <= 1'b1;
            grp   <= last_g ? '0 : grp + 1'b1;
            if (last_g) plane <= last_pl ? '0 : plane + 1'b1;
            state <= S_LOAD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/rgb_bar_scan_chk.sv
module rgb_bar_scan_chk #(
  parameter int ROW_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ROW_W-1:0] row_addr,
  input logic             blank,
  input logic             sclk,
  input logic             latch,
  input logic             sdata
);
  // R5
  latch_blanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> blank);
  // R5
  latch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> !latch);
  // R6
  row_blanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_addr) |-> (blank && $past(blank)));
  // R6
  unblank_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank) |-> (!$past(latch) && $stable(row_addr)));
  // R4
  data_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> !sclk);
  // R4
  sclk_high_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> sclk);
  // R4
  shift_blanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> blank);
endmodule

bind rgb_bar_scan rgb_bar_scan_chk #(.ROW_W($bits(row_addr))) u_chk (
  .clk(clk), .rst_n(rst_n), .row_addr(row_addr), .blank(blank),
  .sclk(sclk), .latch(latch), .sdata(sdata)
);

// File: tb/rgb_bar_scan_bench.sv
`timescale 1ns/1ps
module rgb_bar_scan_bench;
  localparam int BASE = 1;

  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [5:0]  wr_idx = '0;
  logic [23:0] wr_data = '0;
  logic [3:0]  row_addr;
  logic        blank, sclk, latch, sdata;

  rgb_bar_scan #(.BASE_TICKS(BASE)) u_rgb_bar_scan (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .row_addr(row_addr), .blank(blank), .sclk(sclk), .latch(latch), .sdata(sdata)
  );

  always #2.5 clk = ~clk;

  int nvec = 0, nerr = 0;
  bit finished = 0;
  logic [23:0] model [48];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] expw(input int g, input int k);
    logic [15:0] w = '0;
    for (int s = 0; s < 3; s++) begin
      w[3*s]   = model[3*g+s][16+k];
      w[3*s+1] = model[3*g+s][8+k];
      w[3*s+2] = model[3*g+s][k];
    end
    return w;
  endfunction

  // monitor
  int eg, ep, nrise, lowlen, ngroups, cyc, last_rise;
  logic [15:0] sr, lat;
  logic p_blank, p_sclk, p_latch, p_sdata;
  logic [3:0] p_row;
  bit arm = 0, chk_on = 0, done = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      eg = 0; ep = 0; nrise = 0; lowlen = 0; sr = '0; lat = '0; cyc = 0; last_rise = 0;
      p_blank = blank; p_sclk = sclk; p_latch = latch; p_sdata = sdata; p_row = row_addr;
    end else begin
      cyc++;
      if (sclk && !p_sclk) begin
        sr = {sr[14:0], sdata};
        if (chk_on && nrise > 0) chk(cyc - last_rise == 4, "R4 sclk period", cyc - last_rise, 4);
        last_rise = cyc;
        nrise++;
      end
      if (chk_on && sclk && p_sclk) chk(sdata == p_sdata, "R4 sdata moved while sclk high", sdata, p_sdata);
      if (chk_on && sclk) chk(blank, "R4 shift while unblanked", blank, 1);
      if (latch && !p_latch) begin
        if (chk_on) begin
          chk(blank, "R5 latch while unblanked", blank, 1);
          chk(nrise == 16, "R3 bits per word", nrise, 16);
          chk(sr[15:9] == 0, "R3 padding bits", sr[15:9], 0);
        end
        lat = sr;
        nrise = 0;
      end
      if (chk_on && latch && p_latch) chk(0, "R5 latch wider than one clock", 2, 1);
      if (chk_on && row_addr != p_row) chk(blank && p_blank, "R6 row moved while lit", {blank, p_blank}, 3);
      if (!blank && p_blank) begin
        if (chk_on) begin
          chk(row_addr == eg, "R8 group order", row_addr, eg);
          chk(lat == expw(eg, ep), "R3 R1 shifted word", lat, expw(eg, ep));
          chk(!p_latch, "R6 unblank right after latch", p_latch, 0);
          ngroups++;
        end
        lowlen = 0;
      end
      if (!blank) lowlen++;
      if (blank && !p_blank) begin
        if (chk_on) chk(lowlen == (BASE << ep), "R7 unblank length", lowlen, BASE << ep);
        if (eg == 15 && ep == 7) begin
          if (chk_on) begin
            chk(ngroups == 128, "R8 groups per frame", ngroups, 128);
            chk_on = 0; done = 1;
          end else if (arm) begin
            arm = 0; chk_on = 1; ngroups = 0;
          end
        end
        if (eg == 15) begin eg = 0; ep = (ep + 1) % 8; end else eg++;
      end
      p_blank = blank; p_sclk = sclk; p_latch = latch; p_sdata = sdata; p_row = row_addr;
    end
  end

  task automatic wr(input int idx, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = 6'(idx); wr_data = d;
    if (idx < 48) model[idx] = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run_frame();
    arm = 1;
    wait (done);
    done = 0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 48; i++) model[i] = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(blank == 1, "R9 blank", blank, 1);
    chk(latch == 0, "R9 latch", latch, 0);
    chk(sclk == 0, "R9 sclk", sclk, 0);
    chk(sdata == 0, "R9 sdata", sdata, 0);
    chk(row_addr == 0, "R9 row", row_addr, 0);
    rst_n = 1;
  endtask

  task automatic t_zero_frame();
    // R9: memory cleared, every word zero
    run_frame();
  endtask

  task automatic t_pattern();
    // R1: distinct colour per segment
    for (int i = 0; i < 48; i++)
      wr(i, {8'(i*37+5), 8'(i*91+17), 8'(i*13) ^ 8'hA5});
    run_frame();
  endtask

  task automatic t_ignore_high();
    // R2: indexes 48..63 leave stored colours untouched
    for (int i = 48; i < 64; i++) wr(i, 24'hFFFFFF);
    run_frame();
  endtask

  task automatic t_edges();
    // R1 R3: full-on, single bits and clearing at both ends of the bar
    wr(0, 24'hFFFFFF);
    wr(20, 24'h80_01_55);
    wr(47, 24'h000000);
    wr(46, 24'h01_80_AA);
    run_frame();
  endtask

  initial begin
    t_reset();
    t_zero_frame();
    t_pattern();
    t_ignore_high();
    t_edges();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nvec++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule